// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block arbitrates atomic read-modify-write sequences for several hardware threads that share one memory system. A thread opens a sequence with a load-linked request. The monitor passes the read on to memory and keeps a private reservation for that thread: the full word address and a link flag. The thread closes the sequence with a store-conditional. The write reaches memory only while the link flag still stands. The response carries a success flag that the pipeline places in the store's destination register.

The monitor drops a reservation when the reserved cache block is disturbed in any of these ways:
- a write from an outside agent, seen on the snoop port, lands anywhere in that block;
- another thread stores into that block;
- another thread completes a store-conditional into that block.

Every request gets a registered response one cycle later, together with the memory command it produces. The processor pipeline and the memory array sit outside this block.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no response or memory command is pending, and no thread holds a link. A store-conditional issued first after reset fails.
- R2: Each request produces a response one cycle later that carries the requester's thread id. A load (req_op 2'b00) or a load-linked (req_op 2'b10) raises mem_rd_en with mem_addr equal to the request address and returns flag 0.
- R3: A store-conditional (req_op 2'b11) succeeds when the thread's link is set and its address equals the reserved word address. It then raises mem_wr_en with the request's address and data and returns flag 1.
- R4: A store-conditional without a standing link writes nothing (mem_wr_en low) and returns flag 0.
- R5: Any store-conditional, whether it succeeds or fails, clears the requesting thread's link. A second store-conditional with no new load-linked fails.
- R6: A new load-linked from a thread replaces that thread's earlier reservation address.
- R7: A snoop anywhere in the reserved 32-byte block clears the link. Blocks are aligned on addr[4:0]. A snoop outside the block leaves the link intact.
- R8: A store-conditional to an address other than the reserved word fails, even inside the same block and with the link set.
- R9: A plain store (req_op 2'b01) always writes and returns flag 0. A store by another thread into the reserved block clears the link. A load by another thread does not clear it.
- R10: A snoop into the target block in the same cycle as a store-conditional makes that store-conditional fail.
- R11: Reservations are per thread. A snoop that clears one thread's link leaves a different thread's reservation in another block untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_tid | input | TIDW | Requesting thread |
| req_addr | input | AW | Byte address of the request |
| req_wdata | input | DW | Store data |
| snp_valid | input | 1 | A write by an outside agent is observed |
| snp_addr | input | AW | Address of the observed write |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_tid | output | TIDW | Thread the response belongs to |
| rsp_flag | output | 1 | Store-conditional success; 0 for other operations |
| mem_rd_en | output | 1 | Read command to memory |
| mem_wr_en | output | 1 | Write command to memory |
| mem_addr | output | AW | Memory command address |
| mem_wdata | output | DW | Memory write data |

## Verification
The store-conditional is tried in several setups and the bench compares its write and flag against the expected outcome:
- a clean load-linked/store-conditional pair;
- the pair with intervening traffic: snoops inside and just outside the block, and loads versus stores from the other thread;
- a repeated store-conditional;
- a store-conditional aimed at an old or neighbouring word;
- a snoop that arrives in the very cycle of the store-conditional.

The in-block and out-of-block snoops separate block-granular clearing from word-granular clearing. The other-thread load and store separate read from write disturbance. The two-thread case shows that a snoop clears only the reservation whose block it hits.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LD = 2'b00,
    OP_ST = 2'b01,
    OP_LL = 2'b10,
    OP_SC = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_rsv_slot.sv
module llsc_rsv_slot #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          kill_i,
  input  logic          consume_i,
  input  logic [AW-1:0] addr_i,
  output logic          link_o,
  output logic [AW-1:0] rsv_addr_o
);
  logic          link_q, link_d, en;
  logic [AW-1:0] addr_q, addr_d;

  // a fresh load-linked wins over a kill in the same cycle
  always_comb begin
    en     = set_i | kill_i | consume_i;
    link_d = set_i;
    addr_d = set_i ? addr_i : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  link_q <= 1'b0;
    else if (en) link_q <= link_d;
  end

  always_ff @(posedge clk) begin
    if (set_i) addr_q <= addr_d;
  end

  assign link_o     = link_q;
  assign rsv_addr_o = addr_q;
endmodule

// File: rtl/llsc_rsp_reg.sv
module llsc_rsp_reg #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int TIDW = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  logic [TIDW-1:0] tid_i,
  input  logic            flag_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  output logic            vld_o,
  output logic [TIDW-1:0] tid_o,
  output logic            flag_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      flag_o <= 1'b0;
      rd_o   <= 1'b0;
      wr_o   <= 1'b0;
    end else begin
      vld_o  <= vld_i;
      flag_o <= flag_i;
      rd_o   <= rd_i;
      wr_o   <= wr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (vld_i) begin
      tid_o  <= tid_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NTHR    = 2,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int BLK_OFS = 5,
  localparam int TIDW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [TIDW-1:0] req_tid,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic            snp_valid,
  input  logic [AW-1:0]   snp_addr,
  output logic            rsp_valid,
  output logic [TIDW-1:0] rsp_tid,
  output logic            rsp_flag,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata
);
  import llsc_pkg::*;

  localparam int BW = AW - BLK_OFS;

  llsc_op_e            op;
  logic                tid_ok, is_ld, is_st, is_ll, is_sc;
  logic                snp_on_req, sc_commit;
  logic [NTHR-1:0]     link_vec;
  logic [AW-1:0]       rsv_addr [NTHR];
  logic [NTHR-1:0]     set_vec, kill_vec, cons_vec;
  logic                link_sel;
  logic [AW-1:0]       rsv_sel;

  always_comb begin
    op       = llsc_op_e'(req_op);
    tid_ok   = 32'(req_tid) < NTHR;
    is_ld    = req_valid && op == OP_LD;
    is_st    = req_valid && op == OP_ST;
    is_ll    = req_valid && op == OP_LL && tid_ok;
    is_sc    = req_valid && op == OP_SC;
    link_sel = 1'b0;
    rsv_sel  = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (tid_ok && 32'(req_tid) == t) begin
        link_sel = link_vec[t];
        rsv_sel  = rsv_addr[t];
      end
    end
    snp_on_req = snp_valid && snp_addr[AW-1:BLK_OFS] == req_addr[AW-1:BLK_OFS];
    sc_commit  = is_sc && tid_ok && link_sel && rsv_sel == req_addr && !snp_on_req;
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_slot
    logic [BW-1:0] blk;
    logic          hit_snp, hit_peer;

    always_comb begin
      blk         = rsv_addr[g][AW-1:BLK_OFS];
      hit_snp     = snp_valid && blk == snp_addr[AW-1:BLK_OFS];
      hit_peer    = (is_st || sc_commit) && 32'(req_tid) != g
                    && blk == req_addr[AW-1:BLK_OFS];
      set_vec[g]  = is_ll && 32'(req_tid) == g;
      cons_vec[g] = is_sc && 32'(req_tid) == g;
      kill_vec[g] = link_vec[g] && (hit_snp || hit_peer);
    end

    llsc_rsv_slot #(.AW(AW)) i_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_vec[g]),
      .kill_i     (kill_vec[g]),
      .consume_i  (cons_vec[g]),
      .addr_i     (req_addr),
      .link_o     (link_vec[g]),
      .rsv_addr_o (rsv_addr[g])
    );
  end

  llsc_rsp_reg #(.AW(AW), .DW(DW), .TIDW(TIDW)) i_rsp (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (req_valid),
    .tid_i  (req_tid),
    .flag_i (sc_commit),
    .rd_i   (is_ld || (req_valid && op == OP_LL)),
    .wr_i   (is_st || sc_commit),
    .addr_i (req_addr),
    .data_i (req_wdata),
    .vld_o  (rsp_valid),
    .tid_o  (rsp_tid),
    .flag_o (rsp_flag),
    .rd_o   (mem_rd_en),
    .wr_o   (mem_wr_en),
    .addr_o (mem_addr),
    .data_o (mem_wdata)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NTHR    = 2,
  parameter int AW      = 16,
  parameter int BLK_OFS = 5,
  parameter int TIDW    = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      req_op,
  input logic [TIDW-1:0] req_tid,
  input logic            snp_valid,
  input logic [AW-1:0]   snp_addr,
  input logic            rsp_valid,
  input logic            rsp_flag,
  input logic            mem_wr_en,
  input logic [NTHR-1:0] link_vec,
  input logic [AW-1:0]   rsv_addr [NTHR]
);
  // R2: one response per request, one cycle later
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3: a store-conditional writes exactly when it reports success
  p_sc_write_is_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> (mem_wr_en == rsp_flag));

  // R4: no success without a link
  p_sc_needs_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11 && !link_vec[req_tid]) |=> !rsp_flag);

  // R5: the link is gone after any store-conditional
  p_sc_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |=> !link_vec[$past(req_tid)]);

  // R9: a successful flag never appears on a non-conditional response
  p_flag_sc_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op != 2'b11) |=> !rsp_flag);

  // R7: a snoop inside a reserved block drops that link unless relinked
  for (genvar g = 0; g < NTHR; g++) begin : g_chk
    p_snoop_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && link_vec[g]
       && snp_addr[AW-1:BLK_OFS] == rsv_addr[g][AW-1:BLK_OFS]
       && !(req_valid && req_op == 2'b10 && 32'(req_tid) == g))
      |=> !link_vec[g]);
  end
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .NTHR(NTHR), .AW(AW), .BLK_OFS(BLK_OFS), .TIDW(TIDW)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_tid   (req_tid),
  .snp_valid (snp_valid),
  .snp_addr  (snp_addr),
  .rsp_valid (rsp_valid),
  .rsp_flag  (rsp_flag),
  .mem_wr_en (mem_wr_en),
  .link_vec  (link_vec),
  .rsv_addr  (rsv_addr)
);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [0:0]    req_tid;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          snp_valid;
  logic [AW-1:0] snp_addr;
  logic          rsp_valid, rsp_flag, mem_rd_en, mem_wr_en;
  logic [0:0]    rsp_tid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  llsc_monitor i_llsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_tid(req_tid), .req_addr(req_addr), .req_wdata(req_wdata),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .rsp_valid(rsp_valid),
    .rsp_tid(rsp_tid), .rsp_flag(rsp_flag), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of request and/or snoop, then sample the registered result
  task automatic cyc(input logic rv, input logic [1:0] op, input logic t,
                     input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic sv, input logic [AW-1:0] sa);
    @(negedge clk);
    req_valid = rv; req_op = op; req_tid = t; req_addr = a; req_wdata = d;
    snp_valid = sv; snp_addr = sa;
    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b0;
  endtask

  task automatic ll(input logic t, input logic [AW-1:0] a);
    cyc(1'b1, 2'b10, t, a, '0, 1'b0, '0);
  endtask

  task automatic sc_expect(input string tag, input logic t, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic ok);
    cyc(1'b1, 2'b11, t, a, d, 1'b0, '0);
    chk({tag, " flag"}, 32'(rsp_flag), 32'(ok));
    chk({tag, " wr"}, 32'(mem_wr_en), 32'(ok));
    if (ok) begin
      chk({tag, " addr"}, 32'(mem_addr), 32'(a));
      chk({tag, " data"}, mem_wdata, d);
    end
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 mem_wr_en", 32'(mem_wr_en), 0);
    chk("R1 mem_rd_en", 32'(mem_rd_en), 0);
    sc_expect("R1 sc after reset", 1'b0, 16'h0100, 32'h11, 1'b0);
  endtask

  task automatic t_basic;
    ll(1'b0, 16'h0100);
    chk("R2 valid", 32'(rsp_valid), 1);
    chk("R2 rd", 32'(mem_rd_en), 1);
    chk("R2 addr", 32'(mem_addr), 32'h0100);
    chk("R2 flag", 32'(rsp_flag), 0);
    chk("R2 tid", 32'(rsp_tid), 0);
    sc_expect("R3 sc ok", 1'b0, 16'h0100, 32'hA5A5_0001, 1'b1);
    sc_expect("R5 second sc", 1'b0, 16'h0100, 32'h2, 1'b0);
    sc_expect("R4 no link", 1'b1, 16'h0100, 32'h3, 1'b0);
    chk("R2 tid t1", 32'(rsp_tid), 1);
  endtask

  task automatic t_replace;
    ll(1'b0, 16'h0100); ll(1'b0, 16'h0200);
    sc_expect("R6 old addr", 1'b0, 16'h0100, 32'h4, 1'b0);
    ll(1'b0, 16'h0100); ll(1'b0, 16'h0200);
    sc_expect("R6 new addr", 1'b0, 16'h0200, 32'h5, 1'b1);
  endtask

  task automatic t_snoop;
    ll(1'b0, 16'h0100);
    cyc(1'b0, 2'b00, 1'b0, '0, '0, 1'b1, 16'h011C);
    sc_expect("R7 snoop in block", 1'b0, 16'h0100, 32'h6, 1'b0);
    ll(1'b0, 16'h0100);
    cyc(1'b0, 2'b00, 1'b0, '0, '0, 1'b1, 16'h0120);
    sc_expect("R7 snoop next block", 1'b0, 16'h0100, 32'h7, 1'b1);
  endtask

  task automatic t_mismatch;
    ll(1'b0, 16'h0100);
    sc_expect("R8 other word", 1'b0, 16'h0104, 32'h8, 1'b0);
  endtask

  task automatic t_peer;
    ll(1'b0, 16'h0300);
    cyc(1'b1, 2'b00, 1'b1, 16'h0304, '0, 1'b0, '0);
    sc_expect("R9 peer load", 1'b0, 16'h0300, 32'h9, 1'b1);
    ll(1'b0, 16'h0300);
    cyc(1'b1, 2'b01, 1'b1, 16'h0308, 32'hBEEF, 1'b0, '0);
    chk("R9 store wr", 32'(mem_wr_en), 1);
    chk("R9 store flag", 32'(rsp_flag), 0);
    chk("R9 store data", mem_wdata, 32'hBEEF);
    sc_expect("R9 peer store", 1'b0, 16'h0300, 32'hA, 1'b0);
  endtask

  task automatic t_same_cycle;
    ll(1'b0, 16'h0400);
    cyc(1'b1, 2'b11, 1'b0, 16'h0400, 32'hB, 1'b1, 16'h0410);
    chk("R10 flag", 32'(rsp_flag), 0);
    chk("R10 wr", 32'(mem_wr_en), 0);
  endtask

  task automatic t_indep;
    ll(1'b0, 16'h0500); ll(1'b1, 16'h0600);
    cyc(1'b0, 2'b00, 1'b0, '0, '0, 1'b1, 16'h0508);
    sc_expect("R11 t1 kept", 1'b1, 16'h0600, 32'hC, 1'b1);
    sc_expect("R11 t0 lost", 1'b0, 16'h0500, 32'hD, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_tid = '0; req_addr = '0;
    req_wdata = '0; snp_valid = 1'b0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_replace;
    t_snoop;
    t_mismatch;
    t_peer;
    t_same_cycle;
    t_indep;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule